// File: doc/BRIEF.md
# Memory Window Decoder with Size Probing

This block holds the memory windows of one function on a configuration-style bus. There are up to six windows, and each one has a size fixed when the block is built. Software learns the size of a window by writing all ones into it and reading the value back. The bits that can change form a mask, and that mask shows how big the window is. Software then writes the base it has chosen. The bits below the window size always read as zero, so every window is a power of two in size and is aligned to its own size.

Once memory decoding is switched on, every incoming memory address is checked against all programmed windows. If an address falls inside a window, the block raises a claim one cycle later. The claim carries the window number and the offset of the address inside that window. If two windows overlap, the lower-numbered window wins.

Top module: `bar_window_unit`

## Requirements
- R1: After reset, memory decoding is off, every window reads back 0 and no claim is raised.
- R2: Writing 0xFFFFFFFF to a window of size 2^k reads back as ~(2^k-1), with bits [3:0] (type field: memory space, 32-bit, not prefetchable) equal to 0.
- R3: A value written to a window reads back with the bits below k cleared, and it stays the same until that window is written again.
- R4: A window built with size code 0 always reads back 0 and never claims.
- R5: Select value 7 is the control register, and its bit 0 enables memory decoding. While this bit is 0, no claim is raised. Reading select 7 returns the bit in position 0.
- R6: A valid address inside [base, base+2^k) raises claim in the cycle after it is presented. The claim carries the window index and the offset address minus base.
- R7: A valid address outside every window raises no claim.
- R8: If an address hits several windows, the claim names the lowest-indexed window that hits.
- R9: No claim is raised in a cycle after mem_valid was low.
- R10: Select value 6 reads 0, and writes to it change neither the windows nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 3 | Register select: 0..5 windows, 7 control |
| cfg_we | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_valid | input | 1 | Memory address is valid this cycle |
| mem_addr | input | 32 | Memory address to decode |
| claim | output | 1 | Address was claimed (registered) |
| claim_idx | output | 3 | Index of the claiming window |
| claim_off | output | 32 | Offset of the address inside the claiming window |

## Verification
The assertions assume that the configuration port and the memory address input are driven from the same clock and hold stable values across each rising edge. They also assume that reset is held for at least one edge before any traffic arrives. The bench changes every input on the falling edge and samples registered outputs on the next falling edge. Each configuration write is a single-cycle strobe that is removed before the next one is issued. Enable changes and address probes are issued as separate steps, so every claim depends on exactly one known enable state and one known window programming.

// File: rtl/bar_window_pkg.sv
package bar_window_pkg;

    typedef enum logic [1:0] {
        SEL_WIN  = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_NONE = 2'd2
    } sel_kind_e;

    function automatic sel_kind_e classify_sel(input int unsigned sel,
                                               input int unsigned num_win,
                                               input int unsigned ctl_sel);
        if (sel < num_win)
            return SEL_WIN;
        else if (sel == ctl_sel)
            return SEL_CTL;
        else
            return SEL_NONE;
    endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LOG2   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dec_en,
    output logic [ADDR_W-1:0] rdata,
    output logic              hit
);

    generate
        if (LOG2 == 0) begin : g_absent
            logic unused_absent;
            assign unused_absent = ^{clk, rst_n, wr_en, wdata, addr, dec_en};
            assign rdata = '0;
            assign hit   = 1'b0;
        end else begin : g_present
            localparam int unsigned KEEP_W = ADDR_W - LOG2;

            logic [KEEP_W-1:0] base_d;
            logic [KEEP_W-1:0] base_q;
            logic              unused_low;

            assign unused_low = ^{wdata[LOG2-1:0], addr[LOG2-1:0]};

            always_comb begin
                base_d = base_q;
                if (wr_en)
                    base_d = wdata[ADDR_W-1:LOG2];
            end

            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q <= '0;
                else
                    base_q <= base_d;
            end

            assign rdata = {base_q, {LOG2{1'b0}}};
            assign hit   = dec_en && (addr[ADDR_W-1:LOG2] == base_q);

            // R3
            rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(rdata));
        end
    endgenerate

endmodule

// File: rtl/bar_pick.sv
module bar_pick #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned NUM_WIN = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_WIN-1:0]             match,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] bases,
    input  logic [ADDR_W-1:0]              addr,
    output logic                           any,
    output logic [IDX_W-1:0]               idx,
    output logic [ADDR_W-1:0]              off
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        off = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                off = addr - bases[i];
            end
        end
    end

endmodule

// File: rtl/bar_window_unit.sv
module bar_window_unit
    import bar_window_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned NUM_WIN = 6,
    parameter int unsigned WIN_LOG2 [NUM_WIN] = '{12, 16, 0, 4, 20, 8},
    localparam int unsigned IDX_W  = $clog2(NUM_WIN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              claim,
    output logic [IDX_W-1:0]  claim_idx,
    output logic [ADDR_W-1:0] claim_off
);

    localparam int unsigned CTL_SEL = (1 << IDX_W) - 1;

    typedef struct packed {
        logic              en;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] off;
    } state_t;

    state_t st_d;
    state_t st_q;

    sel_kind_e                      kind;
    logic [NUM_WIN-1:0]             win_we;
    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_rd;
    logic                           pick_any;
    logic [IDX_W-1:0]               pick_idx;
    logic [ADDR_W-1:0]              pick_off;

    function automatic int unsigned log2_of(input logic [IDX_W-1:0] i);
        int unsigned r;
        r = 0;
        for (int k = 0; k < NUM_WIN; k++)
            if (int'(i) == k) r = WIN_LOG2[k];
        return r;
    endfunction

    assign kind = classify_sel(int'(cfg_sel), NUM_WIN, CTL_SEL);

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            assign win_we[g] = cfg_we && (kind == SEL_WIN) && (int'(cfg_sel) == g);

            bar_slot #(
                .ADDR_W (ADDR_W),
                .LOG2   (WIN_LOG2[g])
            ) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (win_we[g]),
                .wdata  (cfg_wdata),
                .addr   (mem_addr),
                .dec_en (mem_valid && st_q.en),
                .rdata  (win_rd[g]),
                .hit    (win_hit[g])
            );
        end
    endgenerate

    bar_pick #(
        .ADDR_W  (ADDR_W),
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) u_pick (
        .match (win_hit),
        .bases (win_rd),
        .addr  (mem_addr),
        .any   (pick_any),
        .idx   (pick_idx),
        .off   (pick_off)
    );

    always_comb begin
        cfg_rdata = '0;
        case (kind)
            SEL_WIN: begin
                for (int k = 0; k < NUM_WIN; k++)
                    if (int'(cfg_sel) == k) cfg_rdata = win_rd[k];
            end
            SEL_CTL:  cfg_rdata = {{(ADDR_W-1){1'b0}}, st_q.en};
            default:  cfg_rdata = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = pick_any;
        st_d.idx = pick_any ? pick_idx : '0;
        st_d.off = pick_any ? pick_off : '0;
        if (cfg_we && kind == SEL_CTL)
            st_d.en = cfg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign claim     = st_q.hit;
    assign claim_idx = st_q.idx;
    assign claim_off = st_q.off;

    // R9
    no_claim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |=> !claim);

    // R5
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !claim);

    // R4
    zero_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (log2_of(claim_idx) != 0));

    // R6
    off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> ({1'b0, claim_off} < ((ADDR_W+1)'(1) << log2_of(claim_idx))));

    // R8
    pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> ((win_hit & ((NUM_WIN'(1) << pick_idx) - NUM_WIN'(1))) == '0));

endmodule

// File: tb/bar_window_unit_bench.sv
module bar_window_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        claim;
    logic [2:0]  claim_idx;
    logic [31:0] claim_off;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bar_window_unit u_bar_window_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .claim     (claim),
        .claim_idx (claim_idx),
        .claim_off (claim_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] val);
        cfg_sel   = sel;
        cfg_wdata = val;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [31:0] val);
        cfg_sel = sel;
        #1;
        val = cfg_rdata;
    endtask

    task automatic probe(input logic vld, input logic [31:0] a,
                         output logic c, output logic [2:0] i, output logic [31:0] o);
        mem_valid = vld;
        mem_addr  = a;
        @(negedge clk);
        c = claim; i = claim_idx; o = claim_off;
        mem_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic c; logic [2:0] i; logic [31:0] o;
        for (int s = 0; s < 6; s++) begin
            cfg_read(3'(s), v);
            check("R1 window reset", v, 32'h0);
        end
        cfg_read(3'd7, v);
        check("R1 enable reset", v, 32'h0);
        check("R1 claim reset", {31'b0, claim}, 32'h0);
        probe(1'b1, 32'h0000_0000, c, i, o);
        check("R1 no claim at zero after reset", {31'b0, c}, 32'h0);
    endtask

    task automatic t_probe_size();
        logic [31:0] v;
        cfg_write(3'd0, 32'hFFFF_FFFF); cfg_read(3'd0, v);
        check("R2 probe 4KiB", v, 32'hFFFF_F000);
        cfg_write(3'd1, 32'hFFFF_FFFF); cfg_read(3'd1, v);
        check("R2 probe 64KiB", v, 32'hFFFF_0000);
        cfg_write(3'd3, 32'hFFFF_FFFF); cfg_read(3'd3, v);
        check("R2 probe 16B", v, 32'hFFFF_FFF0);
        cfg_write(3'd4, 32'hFFFF_FFFF); cfg_read(3'd4, v);
        check("R2 probe 1MiB", v, 32'hFFF0_0000);
        cfg_write(3'd5, 32'hFFFF_FFFF); cfg_read(3'd5, v);
        check("R2 probe 256B", v, 32'hFFFF_FF00);
        check("R2 type bits zero", {28'b0, v[3:0]}, 32'h0);
    endtask

    task automatic t_program();
        logic [31:0] v;
        cfg_write(3'd0, 32'h0001_1ABC);
        cfg_write(3'd1, 32'h0001_0000);
        cfg_write(3'd3, 32'h8000_001C);
        cfg_write(3'd4, 32'h400A_BCDE);
        cfg_write(3'd5, 32'h9000_01FF);
        cfg_read(3'd0, v); check("R3 base win0", v, 32'h0001_1000);
        cfg_read(3'd3, v); check("R3 base win3", v, 32'h8000_0010);
        cfg_read(3'd4, v); check("R3 base win4", v, 32'h4000_0000);
        cfg_read(3'd5, v); check("R3 base win5", v, 32'h9000_0100);
        repeat (3) @(negedge clk);
        cfg_read(3'd1, v); check("R3 base holds", v, 32'h0001_0000);
    endtask

    task automatic t_enable_gate();
        logic c; logic [2:0] i; logic [31:0] o;
        logic [31:0] v;
        probe(1'b1, 32'h4000_0004, c, i, o);
        check("R5 no claim while disabled", {31'b0, c}, 32'h0);
        cfg_write(3'd7, 32'h1);
        cfg_read(3'd7, v);
        check("R5 enable readback", v, 32'h1);
    endtask

    task automatic t_decode();
        logic c; logic [2:0] i; logic [31:0] o;
        probe(1'b1, 32'h4000_0004, c, i, o);
        check("R6 claim win4", {31'b0, c}, 32'h1);
        check("R6 idx win4", {29'b0, i}, 32'h4);
        check("R6 off win4", o, 32'h0000_0004);
        probe(1'b1, 32'h400F_FFFF, c, i, o);
        check("R6 last byte win4 idx", {29'b0, i}, 32'h4);
        check("R6 last byte win4 off", o, 32'h000F_FFFF);
        probe(1'b1, 32'h8000_001F, c, i, o);
        check("R6 win3 idx", {29'b0, i}, 32'h3);
        check("R6 win3 off", o, 32'h0000_000F);
        probe(1'b1, 32'h9000_01AB, c, i, o);
        check("R6 win5 off", o, 32'h0000_00AB);
        probe(1'b1, 32'h8000_0020, c, i, o);
        check("R7 just past win3", {31'b0, c}, 32'h0);
        probe(1'b1, 32'h3FFF_FFFF, c, i, o);
        check("R7 just below win4", {31'b0, c}, 32'h0);
        probe(1'b0, 32'h4000_0004, c, i, o);
        check("R9 idle address", {31'b0, c}, 32'h0);
    endtask

    task automatic t_overlap();
        logic c; logic [2:0] i; logic [31:0] o;
        probe(1'b1, 32'h0001_1234, c, i, o);
        check("R8 overlap claim", {31'b0, c}, 32'h1);
        check("R8 overlap lowest idx", {29'b0, i}, 32'h0);
        check("R8 overlap off", o, 32'h0000_0234);
        probe(1'b1, 32'h0001_2000, c, i, o);
        check("R8 outer window idx", {29'b0, i}, 32'h1);
        check("R8 outer window off", o, 32'h0000_2000);
    endtask

    task automatic t_zero_win();
        logic [31:0] v;
        logic c; logic [2:0] i; logic [31:0] o;
        cfg_write(3'd2, 32'hFFFF_FFFF);
        cfg_read(3'd2, v);
        check("R4 zero window reads 0", v, 32'h0);
        probe(1'b1, 32'h0000_0000, c, i, o);
        check("R4 zero window no claim", {31'b0, c}, 32'h0);
    endtask

    task automatic t_unused_sel();
        logic [31:0] v;
        cfg_write(3'd6, 32'hFFFF_FFFF);
        cfg_read(3'd6, v);
        check("R10 unused select reads 0", v, 32'h0);
        cfg_read(3'd0, v);
        check("R10 win0 untouched", v, 32'h0001_1000);
        cfg_read(3'd7, v);
        check("R10 enable untouched", v, 32'h1);
        cfg_write(3'd6, 32'h0);
        cfg_read(3'd7, v);
        check("R10 enable kept after zero write", v, 32'h1);
    endtask

    task automatic t_disable();
        logic c; logic [2:0] i; logic [31:0] o;
        cfg_write(3'd7, 32'h0);
        probe(1'b1, 32'h0001_1234, c, i, o);
        check("R5 no claim after disable", {31'b0, c}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_probe_size();
        t_program();
        t_enable_gate();
        t_decode();
        t_overlap();
        t_zero_win();
        t_unused_sel();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=running expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule